// File: doc/BRIEF.md
# Abstract Command GPR Access Sequencer

This block reads or writes one general-purpose register of a processor core by driving the abstract-command registers of a debug module. A caller hands it a register index, a direction flag and, for a write, a value. The sequencer then carries out the whole exchange on a simple downstream register port. For a write it loads the data register first. It then issues the command word and polls the abstract control/status register until the busy flag drops. It reads that register once more to collect the error field. A read ends by fetching the data register.

Each downstream access is one request with address, direction and write data, and one response with read data and an ok flag. Only one access is in flight at a time. The result comes back as a one-cycle completion pulse. The pulse carries a two-bit outcome (success, command error, poll timeout, bus error), the three-bit error code captured from the debug module, and the read value. A non-zero error field is cleared in the debug module before completion is signalled.

Top module: `gas_top`

## Requirements
- R1: After reset, op_ready is 1, done_valid is 0 and dbg_req_valid is 0.
- R2: The command word is written to debug address 0x17. Its bits 15:0 hold 0x1000 plus the register index. Bit 16 is 1 for a write and 0 for a read. Bit 17 is 1, bits 22:20 hold 2 (32-bit access), and every other bit is 0. It is written exactly once per operation.
- R3: A write operation stores its data in the data register (debug address 0x04) before the command word is issued. A read operation never writes that register.
- R4: The abstract control/status register (debug address 0x16) is read again for as long as its bit 12 (busy) reads 1. Once busy reads 0 it is read one more time. With B busy polls, a completed command therefore makes B+2 reads of address 0x16.
- R5: When bits 10:8 of the final status read are zero, done_status is 0 (success) and done_err is 0. A read operation then reads address 0x04 once and returns that value on done_rdata. A write operation returns done_rdata 0.
- R6: When bits 10:8 are non-zero, the sequencer writes a word with bits 10:8 all ones to address 0x16. It then completes with done_status 1 and done_err equal to the captured field. Address 0x04 is not read, and done_rdata is 0.
- R7: When POLL_LIMIT consecutive polls all read busy, the operation completes with done_status 2 and done_err 0, after exactly POLL_LIMIT reads of 0x16. POLL_LIMIT-1 busy polls still complete normally.
- R8: A downstream response with dbg_rsp_ok 0 ends the operation at once with done_status 3. No further downstream access follows.
- R9: done_valid is a single-cycle pulse in the cycle after the response to the last access of the operation. op_ready is 1 only while idle. An operation is accepted on op_valid while op_ready is 1.
- R10: A downstream request that is not accepted keeps dbg_req_valid, address, direction and write data unchanged until dbg_req_ready is 1. No request is raised while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Sequencer idle and able to accept |
| op_write | input | 1 | 1 = write register, 0 = read register |
| op_index | input | IDX_W | General-purpose register index |
| op_wdata | input | 32 | Value for a write operation |
| done_valid | output | 1 | Completion pulse |
| done_status | output | 2 | 0 success, 1 command error, 2 poll timeout, 3 bus error |
| done_err | output | 3 | Error field captured from the status register |
| done_rdata | output | 32 | Value read from the register (read success only) |
| dbg_req_valid | output | 1 | Downstream access request |
| dbg_req_ready | input | 1 | Downstream accepts the request |
| dbg_req_addr | output | 7 | Debug register address |
| dbg_req_write | output | 1 | 1 = write access |
| dbg_req_wdata | output | 32 | Write data |
| dbg_rsp_valid | input | 1 | Downstream response |
| dbg_rsp_data | input | 32 | Read data of the response |
| dbg_rsp_ok | input | 1 | Response status, 0 = access failed |

## Verification
No result has a fixed latency from op_valid. It depends on how long the responder stalls dbg_req_ready and on how many polls read busy. The only fixed timing is that completion rises exactly one cycle after the response to the final access. The bench's responder records the cycle of every response it returns. When done_valid is seen on a falling edge, the bench compares the current cycle with that record plus one, and only then reads the result fields and its own access counters. op_ready is checked one falling edge after acceptance, and the absence of further accesses is checked three cycles after completion.

// File: rtl/gas_pkg.sv
package gas_pkg;

  localparam int unsigned DBG_DW = 32;
  localparam int unsigned DBG_AW = 7;
  localparam logic [2:0]  SIZE_CODE = 3'($clog2(DBG_DW / 8));

  localparam logic [DBG_AW-1:0] A_DATA0 = 7'h04;
  localparam logic [DBG_AW-1:0] A_ABSCS = 7'h16;
  localparam logic [DBG_AW-1:0] A_CMD   = 7'h17;

  localparam int unsigned BUSY_BIT  = 12;
  localparam logic [DBG_DW-1:0] CLEAR_WORD = 32'h0000_0700;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_CMDERR  = 2'd1,
    RES_TIMEOUT = 2'd2,
    RES_BUSERR  = 2'd3
  } res_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_ISSUE, S_POLL, S_CHECK, S_CLEAR, S_FETCH
  } seq_e;

  function automatic logic [15:0] gpr_regno(input logic [15:0] idx);
    return 16'h1000 + idx;
  endfunction

  function automatic logic [DBG_DW-1:0] cmd_word(input logic wr, input logic [15:0] regno);
    logic [DBG_DW-1:0] w;
    w = '0;
    w[15:0]  = regno;
    w[16]    = wr;
    w[17]    = 1'b1;
    w[22:20] = SIZE_CODE;
    return w;
  endfunction

  function automatic logic abs_busy(input logic [DBG_DW-1:0] v);
    return v[BUSY_BIT];
  endfunction

  function automatic logic [2:0] abs_cmderr(input logic [DBG_DW-1:0] v);
    return v[10:8];
  endfunction

endpackage

// File: rtl/gas_cmd_build.sv
module gas_cmd_build import gas_pkg::*; #(
  parameter int unsigned IDX_W = 5
) (
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  output logic [DBG_DW-1:0] cmd
);
  logic [15:0] regno;
  assign regno = gpr_regno(16'(idx));
  assign cmd   = cmd_word(wr, regno);
endmodule

// File: rtl/gas_poll_ctr.sv
module gas_poll_ctr #(
  parameter int unsigned LIMIT = 1024,
  parameter int unsigned CW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count,
  output logic          last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end
  assign last = (count == CW'(LIMIT - 1));
endmodule

// File: rtl/gas_link.sv
module gas_link import gas_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [DBG_AW-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DBG_DW-1:0] wdata_i,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [DBG_AW-1:0] req_addr,
  output logic              req_write,
  output logic [DBG_DW-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DBG_DW-1:0] rsp_data,
  input  logic              rsp_ok,
  output logic              done,
  output logic              ok,
  output logic [DBG_DW-1:0] rdata
);
  typedef enum logic [1:0] {L_IDLE, L_REQ, L_WAIT} ph_e;
  ph_e ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= L_IDLE;
      req_addr  <= '0;
      req_write <= 1'b0;
      req_wdata <= '0;
    end else begin
      unique case (ph_q)
        L_IDLE: if (go) begin
          ph_q      <= L_REQ;
          req_addr  <= addr_i;
          req_write <= wr_i;
          req_wdata <= wdata_i;
        end
        L_REQ:  if (req_ready) ph_q <= L_WAIT;
        L_WAIT: if (rsp_valid) ph_q <= L_IDLE;
        default: ph_q <= L_IDLE;
      endcase
    end
  end

  assign req_valid = (ph_q == L_REQ);
  assign done      = (ph_q == L_WAIT) && rsp_valid;
  assign ok        = rsp_ok;
  assign rdata     = rsp_data;
endmodule

// File: rtl/gas_top.sv
module gas_top import gas_pkg::*; #(
  parameter int unsigned IDX_W      = 5,
  parameter int unsigned POLL_LIMIT = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic              op_write,
  input  logic [IDX_W-1:0]  op_index,
  input  logic [DBG_DW-1:0] op_wdata,
  output logic              done_valid,
  output logic [1:0]        done_status,
  output logic [2:0]        done_err,
  output logic [DBG_DW-1:0] done_rdata,
  output logic              dbg_req_valid,
  input  logic              dbg_req_ready,
  output logic [DBG_AW-1:0] dbg_req_addr,
  output logic              dbg_req_write,
  output logic [DBG_DW-1:0] dbg_req_wdata,
  input  logic              dbg_rsp_valid,
  input  logic [DBG_DW-1:0] dbg_rsp_data,
  input  logic              dbg_rsp_ok
);
  localparam int unsigned CW = $clog2(POLL_LIMIT + 1);

  seq_e st_q, st_d;
  logic              wr_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DBG_DW-1:0] wd_q;
  res_e              res_q, fin_res;
  logic              fin;
  logic [2:0]        err_q;
  logic [DBG_DW-1:0] rdata_q;

  logic [DBG_DW-1:0] cmd_word_w;
  logic              acc_go, acc_wr, acc_done, acc_ok;
  logic [DBG_AW-1:0] acc_addr;
  logic [DBG_DW-1:0] acc_wdata, acc_rdata;
  logic [CW-1:0]     poll_count;
  logic              poll_last;

  // named internal events
  logic ev_accept, ev_poll_busy, ev_timeout, ev_buserr, ev_cmd_fail;
  assign ev_accept    = op_valid && op_ready;
  assign ev_poll_busy = (st_q == S_POLL) && acc_done && acc_ok && abs_busy(acc_rdata);
  assign ev_timeout   = ev_poll_busy && poll_last;
  assign ev_buserr    = acc_done && !acc_ok;
  assign ev_cmd_fail  = (st_q == S_CHECK) && acc_done && acc_ok && (abs_cmderr(acc_rdata) != 3'd0);

  gas_cmd_build #(.IDX_W(IDX_W)) u_cmd (
    .wr(wr_q), .idx(idx_q), .cmd(cmd_word_w)
  );

  gas_poll_ctr #(.LIMIT(POLL_LIMIT), .CW(CW)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(ev_accept),
    .inc(ev_poll_busy && !poll_last), .count(poll_count), .last(poll_last)
  );

  gas_link u_link (
    .clk(clk), .rst_n(rst_n), .go(acc_go), .addr_i(acc_addr), .wr_i(acc_wr),
    .wdata_i(acc_wdata), .req_valid(dbg_req_valid), .req_ready(dbg_req_ready),
    .req_addr(dbg_req_addr), .req_write(dbg_req_write), .req_wdata(dbg_req_wdata),
    .rsp_valid(dbg_rsp_valid), .rsp_data(dbg_rsp_data), .rsp_ok(dbg_rsp_ok),
    .done(acc_done), .ok(acc_ok), .rdata(acc_rdata)
  );

  // access chosen by the current step
  always_comb begin
    acc_go    = 1'b1;
    acc_wr    = 1'b0;
    acc_addr  = A_ABSCS;
    acc_wdata = '0;
    unique case (st_q)
      S_LOAD:  begin acc_wr = 1'b1; acc_addr = A_DATA0; acc_wdata = wd_q; end
      S_ISSUE: begin acc_wr = 1'b1; acc_addr = A_CMD;   acc_wdata = cmd_word_w; end
      S_POLL, S_CHECK: ;
      S_CLEAR: begin acc_wr = 1'b1; acc_wdata = CLEAR_WORD; end
      S_FETCH: acc_addr = A_DATA0;
      default: acc_go = 1'b0;
    endcase
  end

  always_comb begin
    st_d    = st_q;
    fin     = 1'b0;
    fin_res = RES_OK;
    unique case (st_q)
      S_IDLE:  if (ev_accept) st_d = op_write ? S_LOAD : S_ISSUE;
      S_LOAD:  if (acc_done) st_d = S_ISSUE;
      S_ISSUE: if (acc_done) st_d = S_POLL;
      S_POLL:  if (acc_done && !abs_busy(acc_rdata)) st_d = S_CHECK;
      S_CHECK: if (acc_done) begin
        if (ev_cmd_fail) st_d = S_CLEAR;
        else if (wr_q) begin st_d = S_IDLE; fin = 1'b1; end
        else st_d = S_FETCH;
      end
      S_CLEAR: if (acc_done) begin st_d = S_IDLE; fin = 1'b1; fin_res = RES_CMDERR; end
      S_FETCH: if (acc_done) begin st_d = S_IDLE; fin = 1'b1; end
      default: st_d = S_IDLE;
    endcase
    if (ev_timeout) begin st_d = S_IDLE; fin = 1'b1; fin_res = RES_TIMEOUT; end
    if (ev_buserr)  begin st_d = S_IDLE; fin = 1'b1; fin_res = RES_BUSERR;  end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      wr_q       <= 1'b0;
      idx_q      <= '0;
      wd_q       <= '0;
      res_q      <= RES_OK;
      err_q      <= '0;
      rdata_q    <= '0;
      done_valid <= 1'b0;
    end else begin
      st_q       <= st_d;
      done_valid <= fin;
      if (ev_accept) begin
        wr_q    <= op_write;
        idx_q   <= op_index;
        wd_q    <= op_wdata;
        err_q   <= '0;
        rdata_q <= '0;
      end
      if (ev_cmd_fail) err_q <= abs_cmderr(acc_rdata);
      if ((st_q == S_FETCH) && acc_done && acc_ok) rdata_q <= acc_rdata;
      if (fin) res_q <= fin_res;
    end
  end

  assign op_ready    = (st_q == S_IDLE);
  assign done_status = res_q;
  assign done_err    = err_q;
  assign done_rdata  = rdata_q;
endmodule

// File: rtl/gas_chk.sv
module gas_chk import gas_pkg::*; #(
  parameter int unsigned POLL_LIMIT = 1024,
  parameter int unsigned CW         = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_ready,
  input logic              done_valid,
  input logic [1:0]        done_status,
  input logic [2:0]        done_err,
  input logic              dbg_req_valid,
  input logic              dbg_req_ready,
  input logic [DBG_AW-1:0] dbg_req_addr,
  input logic              dbg_req_write,
  input logic [DBG_DW-1:0] dbg_req_wdata,
  input logic              dbg_rsp_valid,
  input logic [CW-1:0]     poll_count
);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req_valid && !dbg_req_ready |=> dbg_req_valid && $stable(dbg_req_addr)
      && $stable(dbg_req_write) && $stable(dbg_req_wdata));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> !dbg_req_valid);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  a_r9_done_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(dbg_rsp_valid));

  a_r2_cmd_shape: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req_valid && dbg_req_addr == A_CMD |-> dbg_req_write && dbg_req_wdata[17]
      && dbg_req_wdata[22:20] == 3'd2 && dbg_req_wdata[15:12] == 4'h1
      && dbg_req_wdata[31:23] == '0 && dbg_req_wdata[19:18] == 2'b00);

  a_r6_clear_word: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req_valid && dbg_req_write && dbg_req_addr == A_ABSCS |-> dbg_req_wdata[10:8] == 3'b111);

  a_r5_ok_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_status == RES_OK |-> done_err == 3'd0);

  a_r6_err_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_status == RES_CMDERR |-> done_err != 3'd0);

  a_r7_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    poll_count < CW'(POLL_LIMIT));
endmodule

bind gas_top gas_chk #(.POLL_LIMIT(POLL_LIMIT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_ready(op_ready), .done_valid(done_valid),
  .done_status(done_status), .done_err(done_err), .dbg_req_valid(dbg_req_valid),
  .dbg_req_ready(dbg_req_ready), .dbg_req_addr(dbg_req_addr), .dbg_req_write(dbg_req_write),
  .dbg_req_wdata(dbg_req_wdata), .dbg_rsp_valid(dbg_rsp_valid), .poll_count(poll_count)
);

// File: tb/tb_gas_top.sv
module tb_gas_top;
  localparam int IDX_W = 5;
  localparam int LIM   = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic op_valid, op_ready, op_write;
  logic [IDX_W-1:0] op_index;
  logic [31:0] op_wdata;
  logic done_valid;
  logic [1:0] done_status;
  logic [2:0] done_err;
  logic [31:0] done_rdata;
  logic dbg_req_valid, dbg_req_ready, dbg_req_write;
  logic [6:0] dbg_req_addr;
  logic [31:0] dbg_req_wdata;
  logic dbg_rsp_valid, dbg_rsp_ok;
  logic [31:0] dbg_rsp_data;

  gas_top #(.IDX_W(IDX_W), .POLL_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_write(op_write), .op_index(op_index), .op_wdata(op_wdata),
    .done_valid(done_valid), .done_status(done_status), .done_err(done_err),
    .done_rdata(done_rdata), .dbg_req_valid(dbg_req_valid), .dbg_req_ready(dbg_req_ready),
    .dbg_req_addr(dbg_req_addr), .dbg_req_write(dbg_req_write), .dbg_req_wdata(dbg_req_wdata),
    .dbg_rsp_valid(dbg_rsp_valid), .dbg_rsp_data(dbg_rsp_data), .dbg_rsp_ok(dbg_rsp_ok)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] gpr_init(input int i);
    return 32'hC0DE_0000 ^ (32'(i) * 32'h0101_0101);
  endfunction

  // configuration of the model debug module
  int cfg_busy = 0;
  int cfg_cmderr = 0;
  int cfg_fail = -1;

  // model debug module state
  int cyc = 0;
  int rdy_t = 0;
  logic [31:0] gpr_m [32];
  logic [31:0] d0_m;
  logic [2:0]  cerr_st;
  int busy_left;
  int acc_n, d0_wr_n, d0_rd_n, abs_rd_n, abs_wr_n, cmd_n;
  logic [31:0] last_cmd, last_abs_wdata, d0_at_cmd;
  int last_rsp_cyc;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) gpr_m[i] <= gpr_init(i);
      d0_m <= '0; cerr_st <= '0; busy_left <= 0;
      acc_n <= 0; d0_wr_n <= 0; d0_rd_n <= 0; abs_rd_n <= 0; abs_wr_n <= 0; cmd_n <= 0;
      last_cmd <= '0; last_abs_wdata <= '0; d0_at_cmd <= '0; last_rsp_cyc <= 0;
      dbg_req_ready <= 1'b0; dbg_rsp_valid <= 1'b0; dbg_rsp_ok <= 1'b0; dbg_rsp_data <= '0;
    end else begin
      rdy_t <= rdy_t + 1;
      dbg_req_ready <= (rdy_t % 3) != 1;
      dbg_rsp_valid <= 1'b0;
      if (dbg_req_valid && dbg_req_ready) begin
        acc_n         <= acc_n + 1;
        dbg_rsp_valid <= 1'b1;
        dbg_rsp_ok    <= (acc_n != cfg_fail);
        dbg_rsp_data  <= '0;
        last_rsp_cyc  <= cyc + 1;
        if (dbg_req_write) begin
          if (dbg_req_addr == 7'h04) begin
            d0_m <= dbg_req_wdata; d0_wr_n <= d0_wr_n + 1;
          end else if (dbg_req_addr == 7'h17) begin
            cmd_n <= cmd_n + 1; last_cmd <= dbg_req_wdata; d0_at_cmd <= d0_m;
            busy_left <= cfg_busy; cerr_st <= 3'(cfg_cmderr);
            if (cfg_cmderr == 0) begin
              if (dbg_req_wdata[16]) gpr_m[dbg_req_wdata[4:0]] <= d0_m;
              else d0_m <= gpr_m[dbg_req_wdata[4:0]];
            end
          end else if (dbg_req_addr == 7'h16) begin
            abs_wr_n <= abs_wr_n + 1; last_abs_wdata <= dbg_req_wdata;
            if (dbg_req_wdata[10:8] == 3'b111) cerr_st <= '0;
          end
        end else begin
          if (dbg_req_addr == 7'h16) begin
            abs_rd_n <= abs_rd_n + 1;
            if (busy_left > 0) begin
              dbg_rsp_data <= 32'h0000_1000; busy_left <= busy_left - 1;
            end else dbg_rsp_data <= {21'd0, cerr_st, 8'd0};
          end else if (dbg_req_addr == 7'h04) begin
            d0_rd_n <= d0_rd_n + 1; dbg_rsp_data <= d0_m;
          end
        end
      end
    end
  end

  // R10: a stalled request holds its fields
  logic pv = 1'b0, pr = 1'b0, pw = 1'b0;
  logic [6:0] pa = '0;
  logic [31:0] pd = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr) begin
        chk("R10", "stalled request valid", 32'(dbg_req_valid), 32'd1);
        chk("R10", "stalled request fields", {dbg_req_wdata[23:0], dbg_req_addr, dbg_req_write},
            {pd[23:0], pa, pw});
      end
    end
    pv <= dbg_req_valid; pr <= dbg_req_ready; pa <= dbg_req_addr; pw <= dbg_req_write; pd <= dbg_req_wdata;
  end

  task automatic run_op(input bit wr, input int idx, input logic [31:0] wd,
                        input int busy, input int cerr, input int failk);
    int b_acc, b_d0w, b_d0r, b_absr, b_absw, b_cmd, waited;
    logic [31:0] g_before, exp_cmd;
    @(negedge clk);
    cfg_busy = busy; cfg_cmderr = cerr;
    b_acc = acc_n; b_d0w = d0_wr_n; b_d0r = d0_rd_n; b_absr = abs_rd_n; b_absw = abs_wr_n; b_cmd = cmd_n;
    cfg_fail = (failk < 0) ? -1 : b_acc + failk;
    g_before = gpr_m[idx];
    exp_cmd = 32'h0022_0000 | (wr ? 32'h0001_0000 : 32'h0) | (32'h1000 + 32'(idx));
    op_valid = 1'b1; op_write = wr; op_index = IDX_W'(idx); op_wdata = wd;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R9", "op_ready while busy", 32'(op_ready), 32'd0);
    waited = 0;
    while (!done_valid && waited < 3000) begin @(negedge clk); waited++; end
    if (!done_valid) begin
      n_chk++; n_err++;
      $display("FAIL R9 completion: actual none expected pulse");
      return;
    end
    chk("R9", "done one cycle after last response", 32'(cyc), 32'(last_rsp_cyc + 1));
    if (failk >= 0) begin
      chk("R8", "status", 32'(done_status), 32'd3);
      chk("R8", "accesses", 32'(acc_n - b_acc), 32'(failk + 1));
    end else begin
      chk("R2", "command count", 32'(cmd_n - b_cmd), 32'd1);
      chk("R2", "command word", last_cmd, exp_cmd);
      if (wr) begin
        chk("R3", "data0 writes", 32'(d0_wr_n - b_d0w), 32'd1);
        chk("R3", "data0 before command", d0_at_cmd, wd);
      end else chk("R3", "no data0 write on read", 32'(d0_wr_n - b_d0w), 32'd0);
      if (busy >= LIM) begin
        chk("R7", "status", 32'(done_status), 32'd2);
        chk("R7", "err", 32'(done_err), 32'd0);
        chk("R7", "status reads", 32'(abs_rd_n - b_absr), 32'(LIM));
        chk("R7", "no fetch", 32'(d0_rd_n - b_d0r), 32'd0);
      end else begin
        chk("R4", "status reads", 32'(abs_rd_n - b_absr), 32'(busy + 2));
        if (cerr != 0) begin
          chk("R6", "status", 32'(done_status), 32'd1);
          chk("R6", "err", 32'(done_err), 32'(cerr));
          chk("R6", "clear write", 32'(abs_wr_n - b_absw), 32'd1);
          chk("R6", "clear bits", 32'(last_abs_wdata[10:8]), 32'd7);
          chk("R6", "no fetch", 32'(d0_rd_n - b_d0r), 32'd0);
          chk("R6", "rdata", done_rdata, 32'd0);
        end else begin
          chk("R5", "status", 32'(done_status), 32'd0);
          chk("R5", "err", 32'(done_err), 32'd0);
          if (wr) begin
            chk("R5", "register written", gpr_m[idx], wd);
            chk("R5", "rdata on write", done_rdata, 32'd0);
          end else begin
            chk("R5", "fetch count", 32'(d0_rd_n - b_d0r), 32'd1);
            chk("R5", "rdata", done_rdata, g_before);
          end
        end
      end
    end
    b_acc = acc_n;
    repeat (3) @(negedge clk);
    chk("R8", "no access after completion", 32'(acc_n - b_acc), 32'd0);
    chk("R9", "ready after completion", 32'(op_ready), 32'd1);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_write = 1'b0; op_index = '0; op_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1", "op_ready", 32'(op_ready), 32'd1);
    chk("R1", "done_valid", 32'(done_valid), 32'd0);
    chk("R1", "req_valid", 32'(dbg_req_valid), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // every register: write then read back
    for (int i = 0; i < 32; i++) begin
      run_op(1'b1, i, (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F, i % 4, 0, -1);
      run_op(1'b0, i, 32'h0, (i + 1) % 3, 0, -1);
    end
    // every error code, both directions
    for (int e = 1; e < 8; e++) begin
      run_op(1'b1, e, 32'hDEAD_0000 + 32'(e), e % 3, e, -1);
      run_op(1'b0, 31 - e, 32'h0, (e + 1) % 3, e, -1);
    end
    // poll limit boundary
    run_op(1'b0, 10, 32'h0, LIM - 1, 0, -1);
    run_op(1'b0, 10, 32'h0, LIM, 0, -1);
    run_op(1'b1, 11, 32'h1234_5678, LIM - 1, 0, -1);
    run_op(1'b1, 11, 32'h8765_4321, LIM, 0, -1);
    // bus error at each access position
    for (int k = 0; k < 6; k++) run_op(1'b1, 3, 32'hABCD_0000 + 32'(k), 1, 3, k);
    for (int k = 0; k < 4; k++) run_op(1'b0, 4, 32'h0, 0, 0, k);
    // recovery after errors
    run_op(1'b1, 7, 32'h0BAD_F00D, 2, 0, -1);
    run_op(1'b0, 7, 32'h0, 0, 0, -1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule